// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Protective Shutdown

This block turns a PWM command and a direction command into the four gate-enable signals of a full H-bridge. A full bridge has a high-side and a low-side switch on each of two legs, A and B. While PWM is high, one diagonal pair conducts, and the direction bit chooses which pair. While PWM is low, both low-side switches conduct so that the motor current decays slowly through the bottom of the bridge. Every move from one conducting pattern to another passes through a fixed number of all-off cycles. This dead-time prevents a leg from shorting the supply.

Protective shutdown runs alongside the drive logic. A short-circuit flag turns the bridge off and holds it off until the next rising edge of the PWM input, which acts as the retry point. If PWM is held permanently high, no retry happens. Over-temperature and supply faults (undervoltage, overvoltage, charge-pump failure) hold the bridge off only while they are present. Three registered diagnostic lines report the faults to a host controller:
- short-circuit hold on one line;
- supply faults on a second line;
- temperature on a third line. The temperature prewarning is passed through without latching.

All inputs are synchronous to `clk`.

Top module: `hbg_top`

## Requirements
- R1: While `rst_n` is low, all four gate enables and all three diagnostic lines are low.
- R2: With no fault and PWM high, `dir_in` = 0 drives `gate_hs_a` and `gate_ls_b`, and `dir_in` = 1 drives `gate_hs_b` and `gate_ls_a`. The outputs follow one clock after the sampled command when no dead-time is pending.
- R3: With no fault and PWM low, exactly `gate_ls_a` and `gate_ls_b` are on.
- R4: Any change from one non-off gate pattern to a different one passes through exactly `DEAD_CYC` cycles with all four enables low. A new pattern never directly replaces another.
- R5: The high-side and low-side enables of the same leg are never high together.
- R6: A cycle with `fault_short` high leaves all gates off from the next cycle on. They stay off until PWM is sampled rising (low in one cycle, high in the next) while `fault_short` is low. The drive restarts on the cycle after that edge, provided the dead-time has already elapsed.
- R7: While PWM stays high, a short-circuit shutdown never releases. No retry happens at a 100% duty ratio.
- R8: `fault_overtemp`, `fault_undervolt`, `fault_overvolt` and `fault_pump` each turn all gates off from the next cycle for as long as they are high. The gates are not held off after the fault clears, apart from the dead-time.
- R9: `diag_short` rises one cycle after `fault_short` is sampled high. It falls one cycle after the rising PWM edge that clears the hold.
- R10: `diag_supply` equals the OR of undervoltage, overvoltage and pump failure, delayed by one cycle.
- R11: `diag_temp` equals the OR of `temp_warn` and `fault_overtemp`, delayed by one cycle. `temp_warn` alone has no effect on the gates.
- R12: `dir_in` is captured only in cycles where PWM is low. A change of `dir_in` while PWM stays high does not change the conducting diagonal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM drive command |
| dir_in | input | 1 | Direction command (0: A-high/B-low diagonal) |
| fault_short | input | 1 | Short-circuit flag |
| fault_overtemp | input | 1 | Thermal shutdown flag |
| temp_warn | input | 1 | Temperature prewarning flag |
| fault_undervolt | input | 1 | Supply undervoltage flag |
| fault_overvolt | input | 1 | Supply overvoltage flag |
| fault_pump | input | 1 | Charge-pump failure flag |
| gate_hs_a | output | 1 | Leg A high-side enable |
| gate_ls_a | output | 1 | Leg A low-side enable |
| gate_hs_b | output | 1 | Leg B high-side enable |
| gate_ls_b | output | 1 | Leg B low-side enable |
| diag_short | output | 1 | Short-circuit hold report |
| diag_supply | output | 1 | Supply fault report |
| diag_temp | output | 1 | Temperature report |

## Verification
The bench targets the following corner cases:
- A short pulse in the middle of a high phase. A design that released at the falling edge, or at once when the flag cleared, would turn the gates back on too early.
- A short with PWM stuck high. A design that retried on a timer or on the flag dropping would re-drive the bridge.
- Fault removal during a pending dead-time, and brake-to-drive changes. These catch a dead-time counter that is off by one, or that lets one pattern replace another directly.
- Direction flips during a high phase. These expose a design that samples the direction bit without regard to PWM.
- A prewarning-only interval. This catches a design that wrongly ties the warning into the shutdown path.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;

  typedef enum logic [1:0] {
    BR_OFF   = 2'd0,
    BR_FWD   = 2'd1,
    BR_REV   = 2'd2,
    BR_BRAKE = 2'd3
  } bridge_t;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gates_t;

  // Gate pattern belonging to each bridge state.
  function automatic gates_t gates_of(bridge_t s);
    gates_t g;
    g = '0;
    unique case (s)
      BR_FWD:   begin g.hs_a = 1'b1; g.ls_b = 1'b1; end
      BR_REV:   begin g.hs_b = 1'b1; g.ls_a = 1'b1; end
      BR_BRAKE: begin g.ls_a = 1'b1; g.ls_b = 1'b1; end
      default:  g = '0;
    endcase
    return g;
  endfunction

  // Wanted bridge state from halt request, PWM level and held direction.
  function automatic bridge_t pick_target(logic halt, logic pwm, logic dir);
    if (halt)     return BR_OFF;
    else if (!pwm) return BR_BRAKE;
    else if (dir)  return BR_REV;
    else           return BR_FWD;
  endfunction

endpackage

// File: rtl/hbg_fault_ctl.sv
`timescale 1ns/1ps
module hbg_fault_ctl #(
  parameter int N_SUP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             sc_flag,
  input  logic             ot_flag,
  input  logic             ot_warn,
  input  logic [N_SUP-1:0] sup_fail,
  output logic             halt,
  output logic             pwm_prev,
  output logic             sc_hold,
  output logic             diag_sup,
  output logic             diag_tmp
);

  logic pwm_rise;
  logic sc_block;
  logic sup_any;

  assign sup_any  = |sup_fail;
  assign pwm_rise = pwm_in & ~pwm_prev;
  // A rising PWM edge with no short present releases the hold in that very cycle.
  assign sc_block = sc_flag | (sc_hold & ~pwm_rise);
  assign halt     = sc_block | ot_flag | sup_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_prev <= 1'b0;
      sc_hold  <= 1'b0;
      diag_sup <= 1'b0;
      diag_tmp <= 1'b0;
    end else begin
      pwm_prev <= pwm_in;
      if (sc_flag)       sc_hold <= 1'b1;
      else if (pwm_rise) sc_hold <= 1'b0;
      diag_sup <= sup_any;
      diag_tmp <= ot_warn | ot_flag;
    end
  end

  AST_SC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sc_flag |=> sc_hold); // R9

  AST_SC_NO_RETRY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_hold && pwm_in && pwm_prev) |=> sc_hold); // R7

endmodule

// File: rtl/hbg_dir_sel.sv
`timescale 1ns/1ps
module hbg_dir_sel
  import hbg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwm_in,
  input  logic    dir_in,
  input  logic    halt,
  output bridge_t target
);

  logic dir_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_held <= 1'b0;
    else if (!pwm_in) dir_held <= dir_in;
  end

  assign target = pick_target(halt, pwm_in, dir_held);

  AST_DIR_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_in && target == BR_FWD) |=> (!pwm_in || halt || target != BR_REV)); // R12

endmodule

// File: rtl/hbg_deadtime_fsm.sv
`timescale 1ns/1ps
module hbg_deadtime_fsm
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bridge_t target,
  output bridge_t cur,
  output gates_t  gates
);

  localparam int DCW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [DCW-1:0] LOAD = DCW'(DEAD_CYC - 1);

  logic [DCW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= BR_OFF;
      dcnt <= '0;
    end else if (cur != BR_OFF) begin
      if (target != cur) begin
        cur  <= BR_OFF;
        dcnt <= LOAD;
      end
    end else if (dcnt != '0) begin
      dcnt <= dcnt - 1'b1;
    end else begin
      cur <= target;
    end
  end

  assign gates = gates_of(cur);

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates.hs_a && gates.ls_a)); // R5

  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates.hs_b && gates.ls_b)); // R5

  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != BR_OFF) |=> (cur == BR_OFF || $stable(cur))); // R4

  AST_DEAD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != BR_OFF && target != cur) |=> (cur == BR_OFF && dcnt == LOAD)); // R4

  AST_EXIT_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == BR_OFF && dcnt != '0) |=> (cur == BR_OFF)); // R4

endmodule

// File: rtl/hbg_top.sv
`timescale 1ns/1ps
module hbg_top
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic dir_in,
  input  logic fault_short,
  input  logic fault_overtemp,
  input  logic temp_warn,
  input  logic fault_undervolt,
  input  logic fault_overvolt,
  input  logic fault_pump,
  output logic gate_hs_a,
  output logic gate_ls_a,
  output logic gate_hs_b,
  output logic gate_ls_b,
  output logic diag_short,
  output logic diag_supply,
  output logic diag_temp
);

  localparam int N_SUP = 3;

  logic [N_SUP-1:0] sup_vec;
  logic             halt;
  logic             pwm_prev;
  bridge_t          target;
  bridge_t          cur;
  gates_t           gates;
  logic             any_gate;

  assign sup_vec = {fault_pump, fault_overvolt, fault_undervolt};

  hbg_fault_ctl #(.N_SUP(N_SUP)) fault_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_in   (pwm_in),
    .sc_flag  (fault_short),
    .ot_flag  (fault_overtemp),
    .ot_warn  (temp_warn),
    .sup_fail (sup_vec),
    .halt     (halt),
    .pwm_prev (pwm_prev),
    .sc_hold  (diag_short),
    .diag_sup (diag_supply),
    .diag_tmp (diag_temp)
  );

  hbg_dir_sel dir_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .dir_in (dir_in),
    .halt   (halt),
    .target (target)
  );

  hbg_deadtime_fsm #(.DEAD_CYC(DEAD_CYC)) fsm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (target),
    .cur    (cur),
    .gates  (gates)
  );

  assign gate_hs_a = gates.hs_a;
  assign gate_ls_a = gates.ls_a;
  assign gate_hs_b = gates.hs_b;
  assign gate_ls_b = gates.ls_b;
  assign any_gate  = gate_hs_a | gate_ls_a | gate_hs_b | gate_ls_b;

  AST_SHORT_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_short |=> !any_gate); // R6

  AST_HELD_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_short && pwm_in && pwm_prev) |=> !any_gate); // R7

  AST_SUPPLY_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_undervolt || fault_overvolt || fault_pump) |=> (!any_gate && diag_supply)); // R8

  AST_OVERTEMP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_overtemp |=> (!any_gate && diag_temp)); // R8

  AST_WARN_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    temp_warn |=> diag_temp); // R11

endmodule

// File: tb/hbg_top_tb_top.sv
`timescale 1ns/1ps
module hbg_top_tb_top;

  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, dir_in = 1'b0;
  logic fault_short = 1'b0, fault_overtemp = 1'b0, temp_warn = 1'b0;
  logic fault_undervolt = 1'b0, fault_overvolt = 1'b0, fault_pump = 1'b0;
  logic gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b;
  logic diag_short, diag_supply, diag_temp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hbg_top #(.DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dir_in(dir_in),
    .fault_short(fault_short), .fault_overtemp(fault_overtemp),
    .temp_warn(temp_warn), .fault_undervolt(fault_undervolt),
    .fault_overvolt(fault_overvolt), .fault_pump(fault_pump),
    .gate_hs_a(gate_hs_a), .gate_ls_a(gate_ls_a),
    .gate_hs_b(gate_hs_b), .gate_ls_b(gate_ls_b),
    .diag_short(diag_short), .diag_supply(diag_supply), .diag_temp(diag_temp)
  );

  // Behavioural reference: mode 0 idle, 1 forward, 2 reverse, 3 brake.
  int  m_mode, m_wait;
  bit  m_short, m_dir, m_last_pwm, m_dsup, m_dtmp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_wait = 0; m_short = 0; m_dir = 0;
      m_last_pwm = 0; m_dsup = 0; m_dtmp = 0;
    end else begin
      bit edge_up, stop;
      int want;
      edge_up = pwm_in && !m_last_pwm;
      stop = fault_short || (m_short && !edge_up) || fault_overtemp
             || fault_undervolt || fault_overvolt || fault_pump;
      if (stop)        want = 0;
      else if (!pwm_in) want = 3;
      else             want = m_dir ? 2 : 1;
      if (m_mode != 0) begin
        if (want != m_mode) begin m_mode = 0; m_wait = DEAD - 1; end
      end else if (m_wait > 0) m_wait--;
      else m_mode = want;
      if (fault_short) m_short = 1;
      else if (edge_up) m_short = 0;
      if (!pwm_in) m_dir = dir_in;
      m_last_pwm = pwm_in;
      m_dsup = fault_undervolt || fault_overvolt || fault_pump;
      m_dtmp = temp_warn || fault_overtemp;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pattern(int mode);
    case (mode)
      1: return 4'b1001;  // hs_a, ls_b
      2: return 4'b0110;  // ls_a, hs_b
      3: return 4'b0101;  // ls_a, ls_b
      default: return 0;
    endcase
  endfunction

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 R3 R4 R6 R7 R8 R12 gates",
          {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b}, pattern(m_mode));
      chk("R9 R10 R11 diag", {diag_short, diag_supply, diag_temp},
          {m_short, m_dsup, m_dtmp});
      chk("R5 leg exclusion", int'((gate_hs_a & gate_ls_a) | (gate_hs_b & gate_ls_b)), 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pwm_cycles(int periods, int hi, int lo);
    for (int p = 0; p < periods; p++) begin
      pwm_in = 1'b1; step(hi);
      pwm_in = 1'b0; step(lo);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    chk("R1 reset gates", {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b}, 0);
    chk("R1 reset diag", {diag_short, diag_supply, diag_temp}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(2);
    // Forward then reverse drive, with brake and dead-time in between.
    pwm_cycles(3, 12, 10);
    dir_in = 1'b1;
    pwm_cycles(3, 12, 10);
    // R12: direction flip inside a high phase has no effect.
    pwm_in = 1'b1; step(8);
    dir_in = 1'b0; step(4);
    @(negedge clk);
    chk("R12 reverse held", {gate_hs_b, gate_ls_a}, 2'b11);
    @(posedge clk); #1;
    pwm_in = 1'b0; step(10);
    // R6: short pulse mid high phase, release at next rising edge.
    pwm_in = 1'b1; step(6);
    fault_short = 1'b1; step(1);
    fault_short = 1'b0; step(4);
    @(negedge clk);
    chk("R6 off after short", {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b}, 0);
    @(posedge clk); #1;
    pwm_in = 1'b0; step(8);
    pwm_cycles(2, 10, 8);
    // R7: short while PWM held at full duty.
    pwm_in = 1'b1; step(6);
    fault_short = 1'b1; step(2);
    fault_short = 1'b0; step(40);
    @(negedge clk);
    chk("R7 no retry at full duty", {gate_hs_a, gate_hs_b, diag_short}, 3'b001);
    @(posedge clk); #1;
    pwm_in = 1'b0; step(6);
    pwm_cycles(2, 10, 8);
    // R8/R10: each supply fault, one placed in a high phase.
    fault_undervolt = 1'b1; pwm_cycles(1, 10, 8); fault_undervolt = 1'b0;
    pwm_cycles(1, 10, 8);
    pwm_in = 1'b1; step(4);
    fault_overvolt = 1'b1; step(3); fault_overvolt = 1'b0; step(5);
    pwm_in = 1'b0; step(8);
    fault_pump = 1'b1; step(2); fault_pump = 1'b0;
    pwm_cycles(2, 10, 8);
    // R8/R11: thermal shutdown and warning only.
    fault_overtemp = 1'b1; pwm_cycles(1, 10, 8); fault_overtemp = 1'b0;
    temp_warn = 1'b1; pwm_cycles(2, 10, 8);
    @(negedge clk);
    chk("R11 warn gates brake", {gate_ls_a, gate_ls_b, diag_temp}, 3'b111);
    @(posedge clk); #1;
    temp_warn = 1'b0;
    // Short pulses and narrow PWM around the dead-time.
    dir_in = 1'b1;
    pwm_cycles(4, 2, 2);
    pwm_cycles(3, DEAD + 1, DEAD);
    fault_short = 1'b1; pwm_in = 1'b1; step(1);
    fault_short = 1'b0; pwm_in = 1'b0; step(1);
    pwm_cycles(2, 6, 6);
    step(5);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule